// File: doc/BRIEF.md
# Streaming Blob Labeller with Two-Tier Box Selection

This block watches a binary raster, one pixel per accepted beat, and gives every foreground pixel a component number in a single pass. It uses only the pixel to the left and the pixel above, both already numbered. For every number it keeps a bounding rectangle (smallest and largest column and row). When the last pixel of a frame has been taken in, it walks the rectangle table twice. The first walk uses a tight geometric rule and the second a relaxed one. The second walk happens only if the first produced nothing. Each rectangle that passes is emitted on a candidate output, and the block finishes with a done status and a flag that says whether anything was found.

The block suits a plate-finding pipeline placed after the binarisation and morphology filters. It needs no frame store and does not divide anywhere. The width-to-height ratio bounds are checked with shifts and adds.

The controller is a state machine with five states. IDLE is the state after reset. SCAN takes in pixels. STRICT walks the table with the tight rule. LOOSE walks it with the relaxed rule. DONE holds the result. The transitions are as follows:
- IDLE to SCAN, or DONE to SCAN, when a start-of-frame pixel is accepted.
- SCAN to STRICT when the end-of-frame pixel is accepted. IDLE and DONE also go straight to STRICT for a one-pixel frame.
- STRICT to DONE after the last label if any label passed.
- STRICT to LOOSE after the last label if none passed.
- LOOSE to DONE after the last label.

Top module: `ccl_plate_finder`

## Requirements
- R1: A foreground pixel (in_bit=1) takes the left neighbour's label if that label is nonzero. Otherwise it takes the upper neighbour's label if that is nonzero. Otherwise it takes a fresh label. Fresh labels are handed out as 1, 2, 3, … in raster order from each frame start.
- R2: Background pixels (in_bit=0) carry label 0 and never create or enlarge a rectangle.
- R3: When the left and upper labels are both nonzero and differ, the pixel takes the left label, and the left label's rectangle is also stretched to cover the upper position (x, y-1).
- R4: Each label's rectangle is the smallest and largest x and y of all pixels given that label, so every reported rectangle has xmin<=xmax and ymin<=ymax.
- R5: When a fresh label is needed but MAX_LABELS labels are already in use, the pixel gets label 0 and lbl_overflow is set. The flag stays set until the next accepted start-of-frame pixel.
- R6: A rectangle with width W=xmax-xmin+1 and height H=ymax-ymin+1 passes a rule when all of the following hold:
  - H is inside that rule's height range.
  - W is inside that rule's width range.
  - W·H is at least that rule's area floor.
  - 2·H <= W <= 9·H.
- R7: Every label is first tested against the tight rule. Passing rectangles are emitted with cand_tier=0, one per cand_valid pulse, in ascending label order.
- R8: Only when no label passes the tight rule are all labels tested against the relaxed rule. Those are emitted with cand_tier=1, and tier-1 and tier-0 candidates never appear in the same frame.
- R9: After the walks, sel_done rises and holds until the next accepted start-of-frame. sel_none is 1 together with sel_done exactly when no candidate was emitted.
- R10: Pixels on row 0 see no upper neighbour, and pixels in column 0 see no left neighbour. A start-of-frame pixel restarts label allocation and clears the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Pixel beat present |
| in_bit | input | 1 | Binary pixel value |
| in_x | input | XW | Column of the pixel |
| in_y | input | YW | Row of the pixel |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_eof | input | 1 | Pixel is the last of a frame |
| cand_valid | output | 1 | A candidate rectangle is presented this cycle |
| cand_tier | output | 1 | 0 = tight rule, 1 = relaxed rule |
| cand_xmin | output | XW | Candidate left column |
| cand_xmax | output | XW | Candidate right column |
| cand_ymin | output | YW | Candidate top row |
| cand_ymax | output | YW | Candidate bottom row |
| sel_done | output | 1 | Selection finished for the frame |
| sel_none | output | 1 | Selection finished with no candidate |
| lbl_overflow | output | 1 | Label table ran out during this frame |

## Verification
The bench builds the block for a 32×16 raster with only 15 labels. Its tight rule takes heights 3..6, widths 8..20 and areas of at least 30. Its relaxed rule takes heights 2..8, widths 4..24 and areas of at least 8. These small values put label exhaustion within reach of a single row of isolated dots. They also let the exact ratio edges (W=2H and W=9H, one pixel either side) and the left/upper conflict stretch be checked with a few drawn shapes. Mixed rectangles and noise then exercise both tiers and the fallback.

// File: rtl/ccl_pkg.sv
package ccl_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SCAN,
        S_STRICT,
        S_LOOSE,
        S_DONE
    } sel_state_t;

endpackage

// File: rtl/ccl_label_core.sv
module ccl_label_core #(
    parameter int IMG_W      = 640,
    parameter int MAX_LABELS = 255,
    parameter int XW         = 10,
    parameter int YW         = 9,
    parameter int LBL_W      = 8,
    parameter int CNT_W      = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic             sof,
    input  logic             pix,
    input  logic [XW-1:0]    x,
    input  logic [YW-1:0]    y,
    output logic [LBL_W-1:0] lbl,
    output logic             lbl_new,
    output logic             lbl_ext,
    output logic [CNT_W-1:0] next_lbl,
    output logic             ovf
);

    logic [LBL_W-1:0] row_q [IMG_W];
    logic [LBL_W-1:0] prev_q;
    logic [CNT_W-1:0] next_q;
    logic             ovf_q;

    logic [LBL_W-1:0] up_l, left_l;
    logic [CNT_W-1:0] base_next;
    logic             ovf_hit;

    always_comb begin
        up_l      = (y == '0) ? '0 : row_q[x];
        left_l    = (x == '0) ? '0 : prev_q;
        base_next = sof ? CNT_W'(1) : next_q;
        lbl       = '0;
        lbl_new   = 1'b0;
        lbl_ext   = 1'b0;
        ovf_hit   = 1'b0;
        if (pix) begin
            if (left_l != '0) begin
                lbl     = left_l;
                lbl_ext = (up_l != '0) && (up_l != left_l);
            end else if (up_l != '0) begin
                lbl = up_l;
            end else if (base_next <= CNT_W'(MAX_LABELS)) begin
                lbl     = base_next[LBL_W-1:0];
                lbl_new = 1'b1;
            end else begin
                ovf_hit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (acc) row_q[x] <= lbl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            next_q <= CNT_W'(1);
            ovf_q  <= 1'b0;
        end else if (acc) begin
            prev_q <= lbl;
            next_q <= base_next + CNT_W'(lbl_new);
            ovf_q  <= (sof ? 1'b0 : ovf_q) | ovf_hit;
        end
    end

    assign next_lbl = next_q;
    assign ovf      = ovf_q;

endmodule

// File: rtl/ccl_box_table.sv
module ccl_box_table #(
    parameter int MAX_LABELS = 255,
    parameter int XW         = 10,
    parameter int YW         = 9,
    parameter int LBL_W      = 8
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             wr_new,
    input  logic             wr_ext,
    input  logic [LBL_W-1:0] wr_lbl,
    input  logic [XW-1:0]    wr_x,
    input  logic [YW-1:0]    wr_y,
    input  logic [LBL_W-1:0] rd_lbl,
    output logic [XW-1:0]    rd_xmin,
    output logic [XW-1:0]    rd_xmax,
    output logic [YW-1:0]    rd_ymin,
    output logic [YW-1:0]    rd_ymax
);

    logic [XW-1:0] xmin_q [MAX_LABELS+1];
    logic [XW-1:0] xmax_q [MAX_LABELS+1];
    logic [YW-1:0] ymin_q [MAX_LABELS+1];
    logic [YW-1:0] ymax_q [MAX_LABELS+1];

    logic [XW-1:0] nx_min, nx_max;
    logic [YW-1:0] ny_min, ny_max, y_top;

    always_comb begin
        y_top = wr_ext ? (wr_y - YW'(1)) : wr_y;
        if (wr_new) begin
            nx_min = wr_x;
            nx_max = wr_x;
            ny_min = wr_y;
            ny_max = wr_y;
        end else begin
            nx_min = (wr_x < xmin_q[wr_lbl]) ? wr_x : xmin_q[wr_lbl];
            nx_max = (wr_x > xmax_q[wr_lbl]) ? wr_x : xmax_q[wr_lbl];
            ny_min = (y_top < ymin_q[wr_lbl]) ? y_top : ymin_q[wr_lbl];
            ny_max = (wr_y > ymax_q[wr_lbl]) ? wr_y : ymax_q[wr_lbl];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            xmin_q[wr_lbl] <= nx_min;
            xmax_q[wr_lbl] <= nx_max;
            ymin_q[wr_lbl] <= ny_min;
            ymax_q[wr_lbl] <= ny_max;
        end
    end

    assign rd_xmin = xmin_q[rd_lbl];
    assign rd_xmax = xmax_q[rd_lbl];
    assign rd_ymin = ymin_q[rd_lbl];
    assign rd_ymax = ymax_q[rd_lbl];

endmodule

// File: rtl/ccl_box_rule.sv
module ccl_box_rule #(
    parameter int XW   = 10,
    parameter int YW   = 9,
    parameter int HMIN = 20,
    parameter int HMAX = 50,
    parameter int WMIN = 80,
    parameter int WMAX = 300,
    parameter int AMIN = 2000
) (
    input  logic [XW-1:0] xmin,
    input  logic [XW-1:0] xmax,
    input  logic [YW-1:0] ymin,
    input  logic [YW-1:0] ymax,
    output logic          ok
);

    localparam int CW = XW + YW + 4;

    logic [CW-1:0] w, h, area, h2, h9;

    always_comb begin
        w    = CW'(xmax) - CW'(xmin) + CW'(1);
        h    = CW'(ymax) - CW'(ymin) + CW'(1);
        area = w * h;
        h2   = h << 1;
        h9   = (h << 3) + h;
        ok   = (h >= CW'(HMIN)) && (h <= CW'(HMAX)) &&
               (w >= CW'(WMIN)) && (w <= CW'(WMAX)) &&
               (area >= CW'(AMIN)) &&
               (w >= h2) && (w <= h9);
    end

endmodule

// File: rtl/ccl_plate_finder.sv
module ccl_plate_finder #(
    parameter int IMG_W      = 640,
    parameter int IMG_H      = 480,
    parameter int MAX_LABELS = 255,
    parameter int T_HMIN     = 20,
    parameter int T_HMAX     = 50,
    parameter int T_WMIN     = 80,
    parameter int T_WMAX     = 300,
    parameter int T_AMIN     = 2000,
    parameter int R_HMIN     = 10,
    parameter int R_HMAX     = 60,
    parameter int R_WMIN     = 40,
    parameter int R_WMAX     = 320,
    parameter int R_AMIN     = 600,
    localparam int XW        = $clog2(IMG_W),
    localparam int YW        = $clog2(IMG_H)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_bit,
    input  logic [XW-1:0] in_x,
    input  logic [YW-1:0] in_y,
    input  logic          in_sof,
    input  logic          in_eof,
    output logic          cand_valid,
    output logic          cand_tier,
    output logic [XW-1:0] cand_xmin,
    output logic [XW-1:0] cand_xmax,
    output logic [YW-1:0] cand_ymin,
    output logic [YW-1:0] cand_ymax,
    output logic          sel_done,
    output logic          sel_none,
    output logic          lbl_overflow
);
    import ccl_pkg::*;

    localparam int LBL_W = $clog2(MAX_LABELS + 1);
    localparam int CNT_W = LBL_W + 1;

    sel_state_t       st_q, st_nxt;
    logic [CNT_W-1:0] idx_q;
    logic             found_q;

    logic             acc, in_walk, in_range, last, pass_now;
    logic             t_ok, r_ok;
    logic [LBL_W-1:0] px_lbl;
    logic             px_new, px_ext;
    logic [CNT_W-1:0] next_lbl;
    logic [XW-1:0]    bx_xmin, bx_xmax;
    logic [YW-1:0]    bx_ymin, bx_ymax;

    assign in_walk = (st_q == S_STRICT) || (st_q == S_LOOSE);
    assign acc     = in_valid && ((st_q == S_SCAN) ||
                     (((st_q == S_IDLE) || (st_q == S_DONE)) && in_sof));

    ccl_label_core #(
        .IMG_W(IMG_W), .MAX_LABELS(MAX_LABELS),
        .XW(XW), .YW(YW), .LBL_W(LBL_W), .CNT_W(CNT_W)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .acc(acc), .sof(in_sof), .pix(in_bit),
        .x(in_x), .y(in_y), .lbl(px_lbl), .lbl_new(px_new),
        .lbl_ext(px_ext), .next_lbl(next_lbl), .ovf(lbl_overflow)
    );

    ccl_box_table #(
        .MAX_LABELS(MAX_LABELS), .XW(XW), .YW(YW), .LBL_W(LBL_W)
    ) u_table (
        .clk(clk), .wr_en(acc && (px_lbl != '0)), .wr_new(px_new),
        .wr_ext(px_ext), .wr_lbl(px_lbl), .wr_x(in_x), .wr_y(in_y),
        .rd_lbl(idx_q[LBL_W-1:0]),
        .rd_xmin(bx_xmin), .rd_xmax(bx_xmax),
        .rd_ymin(bx_ymin), .rd_ymax(bx_ymax)
    );

    ccl_box_rule #(
        .XW(XW), .YW(YW), .HMIN(T_HMIN), .HMAX(T_HMAX),
        .WMIN(T_WMIN), .WMAX(T_WMAX), .AMIN(T_AMIN)
    ) u_tight (
        .xmin(bx_xmin), .xmax(bx_xmax), .ymin(bx_ymin), .ymax(bx_ymax),
        .ok(t_ok)
    );

    ccl_box_rule #(
        .XW(XW), .YW(YW), .HMIN(R_HMIN), .HMAX(R_HMAX),
        .WMIN(R_WMIN), .WMAX(R_WMAX), .AMIN(R_AMIN)
    ) u_relax (
        .xmin(bx_xmin), .xmax(bx_xmax), .ymin(bx_ymin), .ymax(bx_ymax),
        .ok(r_ok)
    );

    assign in_range = idx_q < next_lbl;
    assign last     = (idx_q + CNT_W'(1)) >= next_lbl;
    assign pass_now = in_range && (((st_q == S_STRICT) && t_ok) ||
                                   ((st_q == S_LOOSE) && r_ok));

    // next-state decode
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            S_IDLE, S_SCAN, S_DONE: begin
                if (acc) st_nxt = in_eof ? S_STRICT : S_SCAN;
            end
            S_STRICT: begin
                if (last) st_nxt = (found_q || pass_now) ? S_DONE : S_LOOSE;
            end
            S_LOOSE: begin
                if (last) st_nxt = S_DONE;
            end
        endcase
    end

    // state register with walk index and hit memory
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= S_IDLE;
            idx_q   <= CNT_W'(1);
            found_q <= 1'b0;
        end else begin
            st_q    <= st_nxt;
            idx_q   <= (in_walk && !last) ? idx_q + CNT_W'(1) : CNT_W'(1);
            if (acc)          found_q <= 1'b0;
            else if (in_walk) found_q <= found_q || pass_now;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_valid <= 1'b0;
            cand_tier  <= 1'b0;
            cand_xmin  <= '0;
            cand_xmax  <= '0;
            cand_ymin  <= '0;
            cand_ymax  <= '0;
            sel_done   <= 1'b0;
            sel_none   <= 1'b0;
        end else begin
            cand_valid <= pass_now;
            cand_tier  <= (st_q == S_LOOSE);
            cand_xmin  <= bx_xmin;
            cand_xmax  <= bx_xmax;
            cand_ymin  <= bx_ymin;
            cand_ymax  <= bx_ymax;
            sel_done   <= (st_nxt == S_DONE);
            sel_none   <= (st_nxt == S_DONE) && !(found_q || pass_now);
        end
    end

endmodule

// File: rtl/ccl_plate_finder_chk.sv
module ccl_plate_finder_chk #(
    parameter int XW = 10,
    parameter int YW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_sof,
    input logic          cand_valid,
    input logic          cand_tier,
    input logic [XW-1:0] cand_xmin,
    input logic [XW-1:0] cand_xmax,
    input logic [YW-1:0] cand_ymin,
    input logic [YW-1:0] cand_ymax,
    input logic          sel_done,
    input logic          sel_none,
    input logic          lbl_overflow
);

    int w_c, h_c;
    assign w_c = int'(cand_xmax) - int'(cand_xmin) + 1;
    assign h_c = int'(cand_ymax) - int'(cand_ymin) + 1;

    assert_box_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> (cand_xmin <= cand_xmax) && (cand_ymin <= cand_ymax));

    assert_ratio_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> (w_c >= 2 * h_c) && (w_c <= 9 * h_c));

    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lbl_overflow && !(in_valid && in_sof) |=> lbl_overflow);

    assert_tight_before_relax_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid && !cand_tier |=> !(cand_valid && cand_tier));

    assert_relax_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid && cand_tier |=> !(cand_valid && !cand_tier));

    assert_none_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_none |-> sel_done);

    assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_done && !(in_valid && in_sof) |=> sel_done);

endmodule

bind ccl_plate_finder ccl_plate_finder_chk #(.XW(XW), .YW(YW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .cand_valid(cand_valid), .cand_tier(cand_tier),
    .cand_xmin(cand_xmin), .cand_xmax(cand_xmax),
    .cand_ymin(cand_ymin), .cand_ymax(cand_ymax),
    .sel_done(sel_done), .sel_none(sel_none), .lbl_overflow(lbl_overflow)
);

// File: tb/ccl_plate_finder_tb_top.sv
`timescale 1ns/1ps
module ccl_plate_finder_tb_top;

    localparam int W  = 32;
    localparam int H  = 16;
    localparam int ML = 15;
    localparam int XW = $clog2(W);
    localparam int YW = $clog2(H);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_bit = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [XW-1:0] in_x = '0;
    logic [YW-1:0] in_y = '0;
    logic cand_valid, cand_tier, sel_done, sel_none, lbl_overflow;
    logic [XW-1:0] cand_xmin, cand_xmax;
    logic [YW-1:0] cand_ymin, cand_ymax;

    always #4 clk = ~clk;

    ccl_plate_finder #(
        .IMG_W(W), .IMG_H(H), .MAX_LABELS(ML),
        .T_HMIN(3), .T_HMAX(6), .T_WMIN(8), .T_WMAX(20), .T_AMIN(30),
        .R_HMIN(2), .R_HMAX(8), .R_WMIN(4), .R_WMAX(24), .R_AMIN(8)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
        .in_x(in_x), .in_y(in_y), .in_sof(in_sof), .in_eof(in_eof),
        .cand_valid(cand_valid), .cand_tier(cand_tier),
        .cand_xmin(cand_xmin), .cand_xmax(cand_xmax),
        .cand_ymin(cand_ymin), .cand_ymax(cand_ymax),
        .sel_done(sel_done), .sel_none(sel_none), .lbl_overflow(lbl_overflow)
    );

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    int img [H][W];
    int e_xmin[ML+1], e_xmax[ML+1], e_ymin[ML+1], e_ymax[ML+1];
    int e_n, e_tier, e_ovf;
    int el_xmin[ML+1], el_xmax[ML+1], el_ymin[ML+1], el_ymax[ML+1];
    int g_n, g_tier[64], g_xmin[64], g_xmax[64], g_ymin[64], g_ymax[64];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_img();
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) img[y][x] = 0;
    endtask

    task automatic rect(input int x0, input int y0, input int w, input int h);
        for (int y = y0; y < y0 + h; y++)
            for (int x = x0; x < x0 + w; x++)
                if (x < W && y < H) img[y][x] = 1;
    endtask

    function automatic bit rule_ok(input int i, input int hmin, input int hmax,
                                   input int wmin, input int wmax, input int amin);
        int w, h;
        w = el_xmax[i] - el_xmin[i] + 1;
        h = el_ymax[i] - el_ymin[i] + 1;
        return h >= hmin && h <= hmax && w >= wmin && w <= wmax &&
               w * h >= amin && w >= 2 * h && w <= 9 * h;
    endfunction

    // reference model built from R1..R10
    task automatic model();
        int row[W];
        int prev, nxt, lab, up, left;
        nxt = 1; e_ovf = 0; prev = 0;
        for (int x = 0; x < W; x++) row[x] = 0;
        for (int y = 0; y < H; y++) begin
            for (int x = 0; x < W; x++) begin
                up   = (y == 0) ? 0 : row[x];
                left = (x == 0) ? 0 : prev;
                lab  = 0;
                if (img[y][x] != 0) begin
                    if (left != 0) begin
                        lab = left;
                        if (up != 0 && up != left && y - 1 < el_ymin[lab])
                            el_ymin[lab] = y - 1;
                    end else if (up != 0) lab = up;
                    else if (nxt <= ML) begin
                        lab = nxt; nxt++;
                        el_xmin[lab] = x; el_xmax[lab] = x;
                        el_ymin[lab] = y; el_ymax[lab] = y;
                    end else e_ovf = 1;
                    if (lab != 0) begin
                        if (x < el_xmin[lab]) el_xmin[lab] = x;
                        if (x > el_xmax[lab]) el_xmax[lab] = x;
                        if (y < el_ymin[lab]) el_ymin[lab] = y;
                        if (y > el_ymax[lab]) el_ymax[lab] = y;
                    end
                end
                row[x] = lab; prev = lab;
            end
        end
        e_n = 0; e_tier = 0;
        for (int i = 1; i < nxt; i++)
            if (rule_ok(i, 3, 6, 8, 20, 30)) begin
                e_xmin[e_n] = el_xmin[i]; e_xmax[e_n] = el_xmax[i];
                e_ymin[e_n] = el_ymin[i]; e_ymax[e_n] = el_ymax[i]; e_n++;
            end
        if (e_n == 0) begin
            e_tier = 1;
            for (int i = 1; i < nxt; i++)
                if (rule_ok(i, 2, 8, 4, 24, 8)) begin
                    e_xmin[e_n] = el_xmin[i]; e_xmax[e_n] = el_xmax[i];
                    e_ymin[e_n] = el_ymin[i]; e_ymax[e_n] = el_ymax[i]; e_n++;
                end
        end
    endtask

    task automatic run_frame(input string tag, input bit gaps);
        int guard;
        model();
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) begin
                @(negedge clk);
                if (gaps && ($urandom % 5 == 0)) begin
                    in_valid = 1'b0;
                    @(negedge clk);
                end
                in_valid = 1'b1; in_bit = img[y][x][0];
                in_x = XW'(x); in_y = YW'(y);
                in_sof = (x == 0 && y == 0);
                in_eof = (x == W - 1 && y == H - 1);
            end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        g_n = 0; guard = 0;
        while (guard < 200) begin
            if (cand_valid && g_n < 64) begin
                g_tier[g_n] = cand_tier;
                g_xmin[g_n] = cand_xmin; g_xmax[g_n] = cand_xmax;
                g_ymin[g_n] = cand_ymin; g_ymax[g_n] = cand_ymax;
                g_n++;
            end
            if (sel_done) break;
            @(negedge clk);
            guard++;
        end
        chk(sel_done == 1'b1, "R9", {tag, " done"}, sel_done, 1);
        chk(sel_none == (e_n == 0), "R9", {tag, " none"}, sel_none, e_n == 0);
        chk(lbl_overflow == e_ovf[0], "R5", {tag, " overflow"}, lbl_overflow, e_ovf);
        chk(g_n == e_n, "R7", {tag, " candidate count"}, g_n, e_n);
        for (int i = 0; i < e_n && i < g_n; i++) begin
            chk(g_tier[i] == e_tier, e_tier ? "R8" : "R7", {tag, " tier"}, g_tier[i], e_tier);
            chk(g_xmin[i] == e_xmin[i] && g_xmax[i] == e_xmax[i], "R4",
                {tag, " x span"}, g_xmin[i] * 100 + g_xmax[i], e_xmin[i] * 100 + e_xmax[i]);
            chk(g_ymin[i] == e_ymin[i] && g_ymax[i] == e_ymax[i], "R3",
                {tag, " y span"}, g_ymin[i] * 100 + g_ymax[i], e_ymin[i] * 100 + e_ymax[i]);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!sel_done && !sel_none && !cand_valid && !lbl_overflow, "R9",
            "reset state", {sel_done, sel_none, cand_valid, lbl_overflow}, 0);
        rst_n = 1'b1;

        clear_img();                         // R2: empty frame
        run_frame("R2 empty", 0);
        clear_img(); rect(3, 2, 12, 4);      // R6/R7 tight pass
        run_frame("R7 tight", 1);
        clear_img(); rect(5, 2, 6, 2); rect(20, 10, 3, 2); // R8 fallback
        run_frame("R8 relaxed", 0);
        clear_img(); rect(3, 2, 12, 4); rect(20, 10, 6, 2); // R7 tight suppresses relaxed
        run_frame("R7 mix", 0);
        clear_img(); rect(8, 0, 2, 3); rect(2, 3, 8, 1);    // R3 conflict stretch
        run_frame("R3 conflict", 0);
        clear_img(); rect(0, 2, 4, 2); rect(10, 2, 3, 2);
        rect(0, 8, 18, 2); rect(0, 12, 19, 2);               // R6 ratio edges
        run_frame("R6 ratio", 0);
        clear_img(); rect(0, 4, 3, 2); rect(5, 4, 4, 1); rect(W - 2, 0, 2, 2); // R10 edges, R1 merge
        rect(0, 0, 4, 2);
        run_frame("R10 edges", 1);
        clear_img();                         // R5 overflow
        for (int x = 0; x < W; x += 2) begin img[0][x] = 1; img[2][x] = 1; end
        rect(4, 8, 12, 4);
        run_frame("R5 exhaust", 0);
        clear_img(); rect(3, 2, 12, 4);      // R10: overflow clears on new frame
        run_frame("R10 restart", 0);
        for (int f = 0; f < 8; f++) begin    // R1 random mixes
            clear_img();
            for (int r = 0; r < 1 + int'($urandom % 3); r++)
                rect(int'($urandom % W), int'($urandom % H),
                     2 + int'($urandom % 16), 1 + int'($urandom % 6));
            for (int k = 0; k < int'($urandom % 12); k++)
                img[$urandom % H][$urandom % W] = 1;
            run_frame("R1 random", 1);
        end
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule